// File: doc/BRIEF.md
# Multistage Cascaded Watchdog Timer

This block is a watchdog built from a chain of countdown stages. Software arms it with `init`, which loads the first stage with its interval. While the first stage is counting, a `kick` restarts it from its interval. If the kicks stop, the first stage runs out and raises its corrective-action line. In the same cycle it starts the second stage. Each later stage then counts its own interval, raises its own action line when it runs out, and starts the stage after it. The last stage raises its line and also fires a hardware reset pulse of programmable width.

A typical wiring takes the stage 1 line to a non-maskable interrupt and to the fail-safe output forcing. The middle stage lines go to state-save or debug-capture requests. The last stage drives the chip reset through `hw_reset`. Kicks only reach the first stage. Once the cascade has begun, software can stop it only with `init` or the synchronous reset.

Top module: `cascade_watchdog`

## Requirements
- R1: After `rst`, and until the first `init`, every bit of `stage_action` is 0 and `hw_reset` is 0, however long the block waits.
- R2: With no kicks, `stage_action[0]` rises in the (I0+1)-th cycle after the `init` edge, where I0 is bits [CNT_W-1:0] of `interval`.
- R3: A kick sampled while stage 1's count is nonzero reloads it, so that `stage_action[0]` rises I0+1 cycles after the last such kick. A kick in the cycle where the count is already zero does not save it.
- R4: A kick has no effect once stage 1 has expired. It does not delay any later stage, and it does not clear any action line.
- R5: Stage i (i>0) loads its interval (bits [(i+1)*CNT_W-1:i*CNT_W]) in the same edge where `stage_action[i-1]` rises, and `stage_action[i]` rises Ii+1 cycles after that.
- R6: Action lines stay high until `init` or `rst`. `stage_action[i]` is never high while `stage_action[i-1]` is low.
- R7: `hw_reset` goes high in the same cycle that the last stage's action rises. It stays high for exactly W cycles, where W is `reset_width`, and a width of 0 acts as 1.
- R8: Only one reset pulse is produced per `init`. After the pulse, all action lines stay high.
- R9: `init` at any time, including mid-cascade or during the pulse, clears all action lines and `hw_reset` on the next edge and restarts stage 1.
- R10: An interval of 0 makes a stage expire on the first edge after it is loaded.
- R11: A stage captures its interval when it is loaded or reloaded. Later changes on `interval` do not alter a count already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; leaves the watchdog idle |
| init | input | 1 | Arms the watchdog: clears all actions, loads stage 1 |
| kick | input | 1 | Restart request for stage 1 |
| interval | input | NUM_STAGES*CNT_W | Per-stage intervals in clocks, stage 0 in the low bits |
| reset_width | input | PW_W | Reset pulse width in clocks (0 acts as 1) |
| stage_action | output | NUM_STAGES | Sticky corrective-action line of each stage |
| hw_reset | output | 1 | Reset pulse driven on last-stage expiry |

## Verification
The bench builds the block with three stages, 8-bit intervals and a 4-bit pulse width. With these values, intervals from 0 to 12 and pulse widths from 0 to 9 give whole cascades lasting only a few dozen cycles, so every trial runs through the final pulse and past it. Intervals of zero, a kick in the exact cycle of expiry, kicks that arrive after the cascade has begun, an interval changed mid-count and an `init` issued mid-cascade are all reachable at that size. Each trial's expected rise cycles are recomputed from the kick history.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } stage_mode_e;

    localparam int unsigned DEF_STAGES = 3;
    localparam int unsigned DEF_CNT_W  = 16;
    localparam int unsigned DEF_PW_W   = 8;

    // A pulse width of zero is widened to one clock.
    function automatic logic [31:0] min_one(input logic [31:0] v);
        return (v == 32'd0) ? 32'd1 : v;
    endfunction

endpackage

// File: rtl/wdog_stage.sv
module wdog_stage
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W    = DEF_CNT_W,
    parameter bit          IS_FIRST = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             start,
    input  logic             kick,
    input  logic [CNT_W-1:0] interval,
    output logic             expire,
    output logic             action
);

    typedef struct packed {
        stage_mode_e      mode;
        logic [CNT_W-1:0] cnt;
        logic             act;
    } stage_t;

    stage_t cur, nxt;

    assign expire = (cur.mode == ST_RUN) && (cur.cnt == '0);
    assign action = cur.act;

    always_comb begin
        nxt = cur;
        if (clr) begin
            nxt.mode = IS_FIRST ? ST_RUN : ST_IDLE;
            nxt.cnt  = interval;
            nxt.act  = 1'b0;
        end else begin
            unique case (cur.mode)
                ST_IDLE: begin
                    if (start) begin
                        nxt.mode = ST_RUN;
                        nxt.cnt  = interval;
                    end
                end
                ST_RUN: begin
                    if (expire) begin
                        nxt.mode = ST_DONE;
                        nxt.act  = 1'b1;
                    end else if (kick) begin
                        nxt.cnt = interval;
                    end else begin
                        nxt.cnt = cur.cnt - CNT_W'(1);
                    end
                end
                default: nxt = cur;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '{mode: ST_IDLE, cnt: '0, act: 1'b0};
        end else begin
            cur <= nxt;
        end
    end

endmodule

// File: rtl/wdog_pulse_gen.sv
module wdog_pulse_gen
    import wdog_pkg::*;
#(
    parameter int unsigned PW_W = DEF_PW_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            trigger,
    input  logic [PW_W-1:0] width,
    output logic            pulse
);

    logic [PW_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            remain <= '0;
        end else if (trigger) begin
            remain <= PW_W'(min_one(32'(width)));
        end else if (remain != '0) begin
            remain <= remain - PW_W'(1);
        end
    end

    assign pulse = (remain != '0);

endmodule

// File: rtl/cascade_watchdog.sv
module cascade_watchdog
    import wdog_pkg::*;
#(
    parameter int unsigned NUM_STAGES = DEF_STAGES,
    parameter int unsigned CNT_W      = DEF_CNT_W,
    parameter int unsigned PW_W       = DEF_PW_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        init,
    input  logic                        kick,
    input  logic [NUM_STAGES*CNT_W-1:0] interval,
    input  logic [PW_W-1:0]             reset_width,
    output logic [NUM_STAGES-1:0]       stage_action,
    output logic                        hw_reset
);

    localparam int unsigned LAST = NUM_STAGES - 1;

    logic [NUM_STAGES-1:0] expire_vec;

    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
        if (i == 0) begin : g_head
            wdog_stage #(.CNT_W(CNT_W), .IS_FIRST(1'b1)) u_stage (
                .clk      (clk),
                .rst      (rst),
                .clr      (init),
                .start    (1'b0),
                .kick     (kick),
                .interval (interval[CNT_W-1:0]),
                .expire   (expire_vec[0]),
                .action   (stage_action[0])
            );
        end else begin : g_tail
            wdog_stage #(.CNT_W(CNT_W), .IS_FIRST(1'b0)) u_stage (
                .clk      (clk),
                .rst      (rst),
                .clr      (init),
                .start    (expire_vec[i-1]),
                .kick     (1'b0),
                .interval (interval[i*CNT_W +: CNT_W]),
                .expire   (expire_vec[i]),
                .action   (stage_action[i])
            );
        end
    end

    wdog_pulse_gen #(.PW_W(PW_W)) u_pulse (
        .clk     (clk),
        .rst     (rst),
        .clr     (init),
        .trigger (expire_vec[LAST]),
        .width   (reset_width),
        .pulse   (hw_reset)
    );

endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
    parameter int unsigned NUM_STAGES = 3
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  init,
    input logic [NUM_STAGES-1:0] stage_action,
    input logic                  hw_reset
);

    localparam int unsigned LAST = NUM_STAGES - 1;

    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (stage_action == '0 && !hw_reset)); // R1

    AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        init |=> (stage_action == '0 && !hw_reset)); // R9

    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_chk
        AST_ACTION_STICKY: assert property (@(posedge clk) disable iff (rst)
            (armed && !init && stage_action[i]) |=> stage_action[i]); // R6
        if (i > 0) begin : g_order
            AST_CASCADE_ORDER: assert property (@(posedge clk) disable iff (rst)
                stage_action[i] |-> stage_action[i-1]); // R6
            AST_STAGE_AFTER_PRED: assert property (@(posedge clk) disable iff (rst)
                (armed && $rose(stage_action[i])) |-> $past(stage_action[i-1])); // R5
        end
    end

    AST_PULSE_NEEDS_LAST: assert property (@(posedge clk) disable iff (rst)
        hw_reset |-> stage_action[LAST]); // R7

    AST_PULSE_STARTS: assert property (@(posedge clk) disable iff (rst)
        (armed && $rose(stage_action[LAST])) |-> hw_reset); // R7

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        (armed && $rose(hw_reset)) |-> $rose(stage_action[LAST])); // R8

endmodule

bind cascade_watchdog wdog_checker #(.NUM_STAGES(NUM_STAGES)) u_wdog_checker (
    .clk          (clk),
    .rst          (rst),
    .init         (init),
    .stage_action (stage_action),
    .hw_reset     (hw_reset)
);

// File: tb/cascade_watchdog_bench.sv
module cascade_watchdog_bench;

    localparam int unsigned NS  = 3;
    localparam int unsigned CW  = 8;
    localparam int unsigned PWW = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              init = 1'b0;
    logic              kick = 1'b0;
    logic [NS*CW-1:0]  iv = '0;
    logic [PWW-1:0]    rw = '0;
    logic [NS-1:0]     act;
    logic              hw;

    int tests = 0;
    int fails = 0;

    cascade_watchdog #(.NUM_STAGES(NS), .CNT_W(CW), .PW_W(PWW)) u_cascade_watchdog (
        .clk          (clk),
        .rst          (rst),
        .init         (init),
        .kick         (kick),
        .interval     (iv),
        .reset_width  (rw),
        .stage_action (act),
        .hw_reset     (hw)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input int actual, input int expected);
        tests++;
        if (actual != expected) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, actual, expected, $time);
        end
    endtask

    function automatic int eff_width(input int w);
        return (w == 0) ? 1 : w;
    endfunction

    // kick_mode 0: no kicks; otherwise a kick with probability 1/kick_mode per cycle
    task automatic run_trial(input string tag, input int i0, input int i1, input int i2,
                             input int pw, input int kick_mode, input bit late_kick,
                             input bit change_iv, input int abort_k);
        int last;
        int r0, r1, r2, w;
        bit kk;
        iv = {i2[CW-1:0], i1[CW-1:0], i0[CW-1:0]};
        rw = pw[PWW-1:0];
        w  = eff_width(pw);
        @(negedge clk);
        init = 1'b1;
        kick = 1'b0;
        @(posedge clk);
        @(negedge clk);
        init = 1'b0;
        last = 0;
        for (int k = 0; ; k++) begin
            r0 = last + i0 + 1;
            r1 = r0 + i1 + 1;
            r2 = r1 + i2 + 1;
            if (k == 0) begin
                chk("R9 init clears actions", int'(act), 0);
                chk("R9 init clears pulse", int'(hw), 0);
            end else begin
                chk(tag, int'(act), int'({k >= r2, k >= r1, k >= r0}));
                chk((k >= r2 + w) ? "R8 after pulse" : "R7 pulse window",
                    int'(hw), int'(k >= r2 && k < r2 + w));
            end
            if (k > r2 + w + 2 || k == abort_k) break;
            kk = 1'b0;
            if (kick_mode != 0 && k < 30)
                kk = ($urandom_range(0, kick_mode - 1) == 0);
            if (late_kick && (k + 1 == last + i0 + 1))
                kk = 1'b1;
            kick = kk;
            if (kk && (k + 1 <= last + i0))
                last = k + 1;
            if (change_iv && k == 1)
                iv[CW-1:0] = CW'(i0 + 7);
            @(posedge clk);
            @(negedge clk);
        end
        kick = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: idle after reset, no init yet
        for (int k = 0; k < 40; k++) begin
            chk("R1 idle actions", int'(act), 0);
            chk("R1 idle pulse", int'(hw), 0);
            kick = (k % 3 == 0);
            @(posedge clk);
            @(negedge clk);
        end
        kick = 1'b0;

        run_trial("R2 no kicks", 5, 3, 4, 3, 0, 1'b0, 1'b0, -1);
        run_trial("R10 zero intervals", 0, 0, 0, 0, 0, 1'b0, 1'b0, -1);
        run_trial("R3 late kick ignored", 4, 2, 2, 2, 0, 1'b1, 1'b0, -1);
        run_trial("R3 frequent kicks", 3, 2, 1, 1, 2, 1'b0, 1'b0, -1);
        run_trial("R4 kicks after expiry", 1, 12, 12, 4, 3, 1'b0, 1'b0, -1);
        run_trial("R11 interval change mid count", 6, 2, 3, 2, 0, 1'b0, 1'b1, -1);
        run_trial("R6 sticky long", 2, 3, 5, 9, 0, 1'b0, 1'b0, -1);
        // R9: init mid-cascade and during the pulse
        run_trial("R9 abort mid cascade", 3, 8, 8, 2, 0, 1'b0, 1'b0, 9);
        run_trial("R9 abort in pulse", 1, 1, 1, 9, 0, 1'b0, 1'b0, 8);
        run_trial("R5 after abort", 2, 4, 1, 5, 0, 1'b0, 1'b0, -1);

        for (int t = 0; t < 30; t++) begin
            run_trial("R5 random cascade",
                      int'($urandom_range(0, 12)), int'($urandom_range(0, 12)),
                      int'($urandom_range(0, 12)), int'($urandom_range(0, 9)),
                      int'($urandom_range(0, 4)), 1'b0, 1'b0, -1);
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule